// File: doc/BRIEF.md
# Round-Robin Conversion Channel Sequencer

This block drives an eight-input conversion engine through every channel whose enable bit is set. It converts each enabled channel once per pass and then starts the next pass. For each channel it counts out a settling interval in clock cycles. The interval depends on the filter word, the filter order and the chop setting. When the interval ends, the block samples the engine's 24-bit result and its error flag into a single output word. It then moves on to the next enabled channel. All sequenced channels share one filter word, order and chop setting, and these inputs are sampled whenever a channel's settling count is loaded.

Only the first conversion of a sequence pays an extra 491-cycle start-up cost. The stream that runs after that conversion uses the shorter per-channel interval. A new enable mask is adopted only when a pass completes. Adopting a different mask restarts the sequence and charges the start-up cost again. A mask of all zeros lets the current pass finish and then parks the block.

Results leave on a valid/ready stream. A word stays on `out_word` while `out_valid` is high and `out_ready` is low. The word transfers on any clock edge where both signals are high. `out_ready` may stay low for as long as the consumer needs. A conversion that finishes while the output slot is still full waits on its channel and does not start the next one, so no result is lost. The conversion inputs and the configuration inputs are plain signals with no handshake.

Top module: `chan_scan_seq`

## Requirements
- R1: Within a pass, the channels are converted in ascending index order, visiting only those whose `chan_mask` bit was set when the pass began. After the highest of them, the sequence wraps to the lowest. A single enabled channel is converted back to back.
- R2: With chop off, each conversion after the first in a sequence takes `ord × BASE_CLKS × fs_word + 16` cycles between consecutive output pushes. `ord` is 4 when `sinc3_sel` = 0 and 3 when `sinc3_sel` = 1. `BASE_CLKS` defaults to 1024.
- R3: With `chop_en` = 1, that interval is doubled: `2 × (ord × BASE_CLKS × fs_word + 16)`.
- R4: The first conversion of a sequence adds 491 cycles to the R2/R3 interval. From idle, the first word is visible `interval + 492` cycles after the mask becomes non-zero, counting from the cycle in which the mask is applied.
- R5: With `stat_en` = 1, `out_word[31:8]` holds the result, bit 7 holds the conversion's error flag, bits 2:0 hold the source channel index, and bits 6:3 are zero.
- R6: With `stat_en` = 0, `out_word` is the result zero-extended to 32 bits. The error flag does not appear in it.
- R7: A change of `chan_mask` takes effect when the current pass completes. If the new mask is different and non-zero, the next conversion is on its lowest channel and pays the R4 extra 491 cycles. If the new mask is zero, the block goes idle after the last channel of the pass.
- R8: While idle (all-zero mask), no word is produced, `out_valid` is low once any pending word has been taken, and `drdy_n` is high.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_word` stays stable and `ch_sel` does not advance. Once released, every result is delivered in order with none dropped.
- R10: `drdy_n` is low exactly while an unconsumed word is on `out_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| chan_mask | input | 8 | Channel enable bits, bit i enables channel i |
| fs_word | input | 10 | Filter word setting the conversion length |
| sinc3_sel | input | 1 | 1 selects third-order filter timing, 0 fourth-order |
| chop_en | input | 1 | 1 doubles the per-channel settling interval |
| stat_en | input | 1 | 1 appends the status byte to each result |
| conv_data | input | 24 | Result from the conversion engine |
| conv_err | input | 1 | Error flag of the current conversion |
| out_ready | input | 1 | Consumer accepts the output word |
| ch_sel | output | 3 | Channel currently being converted |
| drdy_n | output | 1 | Low while a result waits to be read |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 32 | Result, with optional status byte |

## Verification
The main function is exercised with a sparse four-channel mask across two passes, a two-channel mask that spans the lowest and highest indices, and single-channel masks. These tell apart, respectively, ascending order with wrap, correct skipping of disabled channels, and back-to-back reuse of one channel without a start-up charge. A mask change in the middle of a pass separates adoption at the pass boundary from immediate adoption, because the pushes it affects and their spacing differ. The four filter-order and chop combinations produce four distinct intervals, so exchanging order or chop, or omitting the doubling, shows up in the measured spacing. A held-off consumer shows whether the sequencer stalls or overwrites a result.

// File: rtl/css_pkg.sv
package css_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int STAT_W = 8;

  // status byte: error flag on top, channel index in the low three bits
  function automatic logic [STAT_W-1:0] status_tag(input logic err, input logic [2:0] ch_idx);
    return {err, 4'b0000, ch_idx};
  endfunction

endpackage

// File: rtl/css_settle.sv
module css_settle #(
  parameter int FS_W      = 10,
  parameter int BASE_CLKS = 1024,
  parameter int SEQ_PAD   = 16,
  parameter int FIRST_PAD = 491,
  parameter int CW        = 24
) (
  input  logic [FS_W-1:0] fs_word,
  input  logic            sinc3_sel,
  input  logic            chop_en,
  input  logic            first_conv,
  output logic [CW-1:0]   settle_clks
);

  logic [CW-1:0] ord_w;
  logic [CW-1:0] one_pass;
  logic [CW-1:0] per_ch;

  always_comb begin
    ord_w       = sinc3_sel ? CW'(3) : CW'(4);
    one_pass    = ord_w * CW'(BASE_CLKS) * CW'(fs_word) + CW'(SEQ_PAD);
    per_ch      = chop_en ? (one_pass << 1) : one_pass;
    settle_clks = first_conv ? (per_ch + CW'(FIRST_PAD)) : per_ch;
  end

endmodule

// File: rtl/css_lowest.sv
module css_lowest #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] mask,
  output logic [CHW-1:0] low_ch
);

  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) low_ch = CHW'(i);
    end
  end

endmodule

// File: rtl/css_next_up.sv
module css_next_up #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] cur,
  output logic [CHW-1:0] up_ch,
  output logic           up_ok
);

  logic [NCH-1:0] above;

  // one qualifier per channel: enabled and strictly above the current index
  for (genvar g = 0; g < NCH; g++) begin : g_above
    assign above[g] = mask[g] && (CHW'(g) > cur);
  end

  always_comb begin
    up_ch = '0;
    up_ok = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (above[i]) begin
        up_ch = CHW'(i);
        up_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/css_out_stage.sv
module css_out_stage #(
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] load_word,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_word,
  output logic          slot_free
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign slot_free = !out_valid || out_ready;

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq #(
  parameter int NCH       = 8,
  parameter int FS_W      = 10,
  parameter int DW        = 24,
  parameter int BASE_CLKS = 1024,
  parameter int SEQ_PAD   = 16,
  parameter int FIRST_PAD = 491,
  localparam int CHW      = $clog2(NCH),
  localparam int OW       = DW + css_pkg::STAT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  chan_mask,
  input  logic [FS_W-1:0] fs_word,
  input  logic            sinc3_sel,
  input  logic            chop_en,
  input  logic            stat_en,
  input  logic [DW-1:0]   conv_data,
  input  logic            conv_err,
  input  logic            out_ready,
  output logic [CHW-1:0]  ch_sel,
  output logic            drdy_n,
  output logic            out_valid,
  output logic [OW-1:0]   out_word
);
  import css_pkg::*;

  localparam int MAX_CNT = 2 * (4 * BASE_CLKS * ((1 << FS_W) - 1) + SEQ_PAD) + FIRST_PAD;
  localparam int CW      = $clog2(MAX_CNT + 1);

  seq_state_e     state_q;
  logic [NCH-1:0] act_q;
  logic [CHW-1:0] ch_q;
  logic [CW-1:0]  cnt_q;

  logic [CHW-1:0] up_ch, act_low, live_low;
  logic           up_ok;
  logic [CW-1:0]  settle;
  logic           slot_free, start, done, push, restart, first_conv, busy;
  logic [OW-1:0]  load_word;

  css_next_up #(.NCH(NCH), .CHW(CHW)) u_up (
    .mask(act_q), .cur(ch_q), .up_ch(up_ch), .up_ok(up_ok)
  );

  css_lowest #(.NCH(NCH), .CHW(CHW)) u_low_act (
    .mask(act_q), .low_ch(act_low)
  );

  css_lowest #(.NCH(NCH), .CHW(CHW)) u_low_live (
    .mask(chan_mask), .low_ch(live_low)
  );

  assign busy       = (state_q == ST_RUN);
  assign start      = (state_q == ST_IDLE) && (|chan_mask);
  assign done       = busy && (cnt_q == CW'(1));
  assign push       = done && slot_free;
  assign restart    = push && !up_ok && (|chan_mask) && (chan_mask != act_q);
  assign first_conv = start || restart;

  css_settle #(
    .FS_W(FS_W), .BASE_CLKS(BASE_CLKS), .SEQ_PAD(SEQ_PAD),
    .FIRST_PAD(FIRST_PAD), .CW(CW)
  ) u_settle (
    .fs_word(fs_word), .sinc3_sel(sinc3_sel), .chop_en(chop_en),
    .first_conv(first_conv), .settle_clks(settle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      ch_q    <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            act_q   <= chan_mask;
            ch_q    <= live_low;
            cnt_q   <= settle;
          end
        end
        ST_RUN: begin
          if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
          end else if (push) begin
            if (up_ok) begin
              ch_q  <= up_ch;
              cnt_q <= settle;
            end else if (chan_mask == '0) begin
              state_q <= ST_IDLE;
            end else if (restart) begin
              act_q <= chan_mask;
              ch_q  <= live_low;
              cnt_q <= settle;
            end else begin
              ch_q  <= act_low;
              cnt_q <= settle;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_word = stat_en ? {conv_data, status_tag(conv_err, 3'(ch_q))}
                             : {{STAT_W{1'b0}}, conv_data};

  css_out_stage #(.OW(OW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(push), .load_word(load_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
    .slot_free(slot_free)
  );

  assign ch_sel = ch_q;
  assign drdy_n = !out_valid;

endmodule

// File: rtl/css_seq_checker.sv
module css_seq_checker #(
  parameter int NCH = 8,
  parameter int DW  = 24,
  parameter int CHW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [CHW-1:0]  ch_sel,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW+7:0]   out_word,
  input logic [DW-1:0]   conv_data,
  input logic            conv_err,
  input logic            stat_en
);

  // R9: a word held off by the consumer does not change
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R9: a running sequence does not move to another channel while stalled
  a_r9_stall_channel: assert property (@(posedge clk) disable iff (!rst_n)
    busy && out_valid && !out_ready |=> $stable(ch_sel));

  // R5: a freshly pushed tagged word carries the sampled result, error and channel
  a_r5_status_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(stat_en) |->
      out_word[DW+7:8] == $past(conv_data) &&
      out_word[7] == $past(conv_err) &&
      out_word[6:3] == 4'b0000 &&
      out_word[CHW-1:0] == $past(ch_sel));

  // R8: once idle and drained, no new word appears
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (!out_valid || out_ready) |=> !out_valid);

endmodule

bind chan_scan_seq css_seq_checker #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ch_sel(ch_sel),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .conv_data(conv_data), .conv_err(conv_err), .stat_en(stat_en)
);

// File: tb/chan_scan_seq_bench.sv
module chan_scan_seq_bench;

  localparam int BASE = 4;
  localparam int XTRA = 492;  // start-up 491 plus the apply cycle

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chan_mask = '0;
  logic [9:0]  fs_word = 10'd2;
  logic        sinc3_sel = 1'b0, chop_en = 1'b0, stat_en = 1'b1;
  logic [23:0] conv_data;
  logic        conv_err;
  logic        out_ready = 1'b1;
  logic [2:0]  ch_sel;
  logic        drdy_n, out_valid;
  logic [31:0] out_word;

  logic [15:0] seed = 16'h0;
  logic        err_on = 1'b0;
  logic [2:0]  err_ch = 3'd0;

  int checks = 0, failures = 0;
  int cyc = 0, last_t = 0, popped = 0;

  typedef struct {
    logic [31:0] word;
    int          gap;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign conv_data = {seed, 5'd0, ch_sel};
  assign conv_err  = err_on && (ch_sel == err_ch);

  chan_scan_seq #(.BASE_CLKS(BASE)) u_chan_scan_seq (
    .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .fs_word(fs_word),
    .sinc3_sel(sinc3_sel), .chop_en(chop_en), .stat_en(stat_en),
    .conv_data(conv_data), .conv_err(conv_err), .out_ready(out_ready),
    .ch_sel(ch_sel), .drdy_n(drdy_n), .out_valid(out_valid), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side: expected word computed from R5/R6
  task automatic expect_item(input int ch, input int gap, input string tag);
    exp_t e;
    logic [23:0] d;
    logic        er;
    d  = {seed, 5'd0, 3'(ch)};
    er = err_on && (3'(ch) == err_ch);
    e.word = stat_en ? {d, er, 4'b0000, 3'(ch)} : {8'h00, d};
    e.gap  = gap;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic at_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic apply_mask(input logic [7:0] m);
    at_edge();
    chan_mask = m;
    last_t = cyc;
  endtask

  // monitor: pops and compares on every transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected word", 64'(out_word), 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_word == e.word, {e.tag, " word"}, 64'(out_word), 64'(e.word));
        if (e.gap != 0)
          chk((cyc - last_t) == e.gap, {e.tag, " spacing"}, 64'(cyc - last_t), 64'(e.gap));
      end
      last_t = cyc;
      popped++;
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 64'(popped), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset valid", 64'(out_valid), 64'h0);
    chk(drdy_n == 1'b1, "R10 reset drdy_n", 64'(drdy_n), 64'h1);
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle valid", 64'(out_valid), 64'h0);

    // sparse mask, two passes, sinc4 no chop fs=2: N = 48
    seed = 16'hA5C3; err_on = 1'b1; err_ch = 3'd5; stat_en = 1'b1;
    p0 = popped;
    expect_item(1, 48 + XTRA, "R4 R1 R5");
    expect_item(2, 48, "R2 R1 R5");
    expect_item(5, 48, "R2 R1 R5");
    expect_item(7, 48, "R2 R1 R5");
    expect_item(1, 48, "R2 R1 wrap");
    expect_item(2, 48, "R2 R1");
    expect_item(5, 48, "R2 R1");
    expect_item(7, 48, "R7 R1 old mask finishes");
    expect_item(0, 48 + 491, "R7 R4 restart");
    expect_item(3, 48, "R7 R1");
    expect_item(0, 48, "R7 R1");
    expect_item(3, 48, "R7 last before idle");
    apply_mask(8'hA6);
    wait (popped == p0 + 5);
    at_edge();
    chan_mask = 8'h09;
    wait (popped == p0 + 11);
    at_edge();
    chan_mask = 8'h00;
    wait (popped == p0 + 12);
    repeat (700) @(negedge clk);
    chk(out_valid == 1'b0, "R7 R8 idle after pass", 64'(out_valid), 64'h0);
    chk(drdy_n == 1'b1, "R8 R10 idle drdy_n", 64'(drdy_n), 64'h1);
    chk(popped == p0 + 12, "R7 no extra words", 64'(popped), 64'(p0 + 12));

    // sinc3, status off, ends of the index range: N = 40
    seed = 16'h3C10; err_on = 1'b1; err_ch = 3'd7; stat_en = 1'b0; sinc3_sel = 1'b1;
    p0 = popped;
    expect_item(0, 40 + XTRA, "R4 R6");
    expect_item(7, 40, "R2 R6");
    expect_item(0, 40, "R2 R6 wrap");
    expect_item(7, 40, "R2 R6");
    apply_mask(8'h81);
    wait (popped == p0 + 3);
    at_edge();
    chan_mask = 8'h00;
    wait (popped == p0 + 4);
    repeat (300) @(negedge clk);

    // chop, sinc4, single channel: N = 96
    seed = 16'h0F0F; err_on = 1'b0; stat_en = 1'b1; sinc3_sel = 1'b0; chop_en = 1'b1;
    p0 = popped;
    expect_item(2, 96 + XTRA, "R3 R4");
    expect_item(2, 96, "R3 R1 single");
    expect_item(2, 96, "R3 R1 single");
    apply_mask(8'h04);
    wait (popped == p0 + 2);
    at_edge();
    chan_mask = 8'h00;
    wait (popped == p0 + 3);
    repeat (300) @(negedge clk);

    // chop, sinc3, fs=1: N = 2*(12+16) = 56
    seed = 16'h7E01; sinc3_sel = 1'b1; fs_word = 10'd1;
    p0 = popped;
    expect_item(6, 56 + XTRA, "R3 R4 sinc3");
    expect_item(6, 56, "R3 sinc3");
    apply_mask(8'h40);
    wait (popped == p0 + 1);
    at_edge();
    chan_mask = 8'h00;
    wait (popped == p0 + 2);
    repeat (300) @(negedge clk);

    // back-pressure: sinc3 no chop fs=2, N = 40
    seed = 16'hBEEF; chop_en = 1'b0; fs_word = 10'd2;
    p0 = popped;
    expect_item(0, 0, "R9 R1 held");
    expect_item(4, 0, "R9 R1 stalled");
    expect_item(0, 40, "R9 R2 resumed");
    expect_item(4, 40, "R9 R2 resumed");
    at_edge();
    out_ready = 1'b0;
    apply_mask(8'h11);
    wait (out_valid);
    repeat (200) @(negedge clk);
    chk(out_valid == 1'b1, "R9 still valid", 64'(out_valid), 64'h1);
    chk(drdy_n == 1'b0, "R10 drdy_n low", 64'(drdy_n), 64'h0);
    chk(ch_sel == 3'd4, "R9 channel stalled", 64'(ch_sel), 64'h4);
    chk(out_word == {16'hBEEF, 5'd0, 3'd0, 8'h00}, "R9 word held",
        64'(out_word), 64'({16'hBEEF, 5'd0, 3'd0, 8'h00}));
    chk(popped == p0, "R9 nothing taken", 64'(popped), 64'(p0));
    at_edge();
    out_ready = 1'b1;
    wait (popped == p0 + 2);
    at_edge();
    chan_mask = 8'h00;
    wait (popped == p0 + 4);
    repeat (300) @(negedge clk);
    chk(drdy_n == 1'b1, "R10 drained", 64'(drdy_n), 64'h1);
    chk(q.size() == 0, "R1 all expected words seen", 64'(q.size()), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule